// File: doc/BRIEF.md
# UART Register and Interrupt Identification Unit

This block is the processor-side register file of a classic byte-wide serial controller. The host reaches it through a 3-bit offset with separate read and write strobes. The block holds these registers:

- interrupt enable
- line format
- modem control
- scratch
- FIFO control
- a 16-bit baud divisor

It presents line status and modem status to the host. It forms a prioritised interrupt identification code. The serial shifters, FIFO storage and baud counter sit outside the block. They receive its configuration outputs, and they return status and strobe signals to it.

Bit 7 of the format register is the divisor access bit. While it is set, offsets 0 and 1 reach the divisor low and high bytes. While it is clear, offset 0 is the receive buffer on read and the transmit holding register on write, and offset 1 is the interrupt enable register.

Several reads and writes have side effects:

- A read of the receive buffer pops the receive path.
- A write of the transmit holding register loads the transmit path.
- A read of line status clears the latched error flags.
- A read of the identification code while it reports transmitter empty retires that interrupt source.

Each side-effect pulse is combinational and lasts as long as its strobe. The register effects land on the clock edge that ends the strobe cycle.

Top module: `uart_reg_unit`

## Requirements
- R1: After reset, the following hold:
  - Offset 2 reads 0x01.
  - Offsets 1, 3, 4 and 7 read 0x00, and so does offset 5 bits 3:1.
  - `divisor_o` is 0.
  - `irq_o` is low.
- R2: While format bit 7 is 1, a write to offset 0 or 1 loads divisor bits 7:0 or 15:8, and a read returns them. While that bit is 1, an access to offset 0 raises neither `tx_load_o` nor `rx_pop_o`. The divisor changes only through such writes.
- R3: While format bit 7 is 0, the following hold:
  - A write to offset 0 raises `tx_load_o` for the strobe cycle, with `tx_data_o` equal to the write data.
  - A read of offset 0 returns `rx_data_i` and raises `rx_pop_o`.
  - Offset 1 holds the interrupt enables in bits 3:0, and bits 7:4 read 0.
- R4: The format register at offset 3 reads back as written and drives these outputs:
  - bits 1:0 drive `word_len_o`
  - bit 2 drives `two_stop_o`
  - bit 3 drives `parity_en_o`
  - bit 4 drives `even_parity_o`
  - bit 5 drives `stick_parity_o`
  - bit 6 drives `break_o`
- R5: Modem control at offset 4 drives these outputs:
  - bit 0 drives `dtr_o`
  - bit 1 drives `rts_o`
  - bit 3 drives `out2_o`
  - bit 4 drives `loop_o`

  Offset 4 reads back bits 4:0 and reads 0 in bits 7:5. Offset 7 is an 8-bit scratch register that reads back as written.
- R6: A write to offset 2 is FIFO control:
  - Bit 0 sets `fifo_en_o`.
  - Bit 6 sets `rx_trig4_o`.
  - Bit 1 raises `rx_fifo_clr_o` for the strobe cycle, and bit 2 raises `tx_fifo_clr_o` for the strobe cycle.

  Bits 7:6 of a read of offset 2 are 2'b11 while the FIFOs are enabled and 2'b00 otherwise.
- R7: Offset 5 reads line status:
  - bit 0 reads `rx_ready_i`
  - bit 1 latches `rx_overrun_i`
  - bit 2 latches `rx_parity_err_i`
  - bit 3 latches `rx_frame_err_i`
  - bit 5 reads `thr_empty_i`
  - all other bits read 0

  A read of offset 5 clears bits 3:1 on the edge that ends it. A new error pulse on that same edge wins over the clear.
- R8: Bits 3:0 of offset 2 give the highest-priority enabled source, checked in this order:
  1. Code 6 for any latched error, enabled by bit 2 of offset 1.
  2. Code 12 for `rx_timeout_i`, then code 4 for `rx_ready_i`, both enabled by bit 0 of offset 1.
  3. Code 2 for a pending transmitter-empty event, enabled by bit 1 of offset 1.
  4. Code 0 for any of `msr_i` bits 3:0, enabled by bit 3 of offset 1.

  The code is 1 when no enabled source is pending.
- R9: The transmitter-empty event becomes pending on the edge after `thr_empty_i` rises, or after enable bit 1 goes from 0 to 1 while `thr_empty_i` is high. The event is cleared by a write to the transmit holding register. It is also cleared by a read of offset 2 that returns code 2.
- R10: `irq_o` is high exactly when some enabled source is pending and `out2_o` is 1.
- R11: A read of offset 6 returns `msr_i` and raises `msr_read_o` for the strobe cycle.

Interrupt enable bits, all at offset 1:

| Bit | Enables |
|-----|---------|
| 0 | receive data and timeout |
| 1 | transmitter-empty event |
| 2 | latched line error |
| 3 | modem status change |

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| rx_data_i | input | 8 | Head of receive path |
| rx_ready_i | input | 1 | Received data available or trigger level reached |
| rx_timeout_i | input | 1 | Character timeout |
| rx_overrun_i | input | 1 | Overrun pulse |
| rx_parity_err_i | input | 1 | Parity error pulse |
| rx_frame_err_i | input | 1 | Framing error pulse |
| thr_empty_i | input | 1 | Transmit holding register empty |
| msr_i | input | 8 | Modem status byte, deltas in bits 3:0 |
| rx_pop_o | output | 1 | Receive buffer read pulse |
| tx_load_o | output | 1 | Transmit holding write pulse |
| tx_data_o | output | 8 | Transmit data |
| msr_read_o | output | 1 | Modem status read pulse |
| divisor_o | output | 16 | Baud divisor |
| word_len_o | output | 2 | Word length code |
| two_stop_o | output | 1 | Two stop bits |
| parity_en_o | output | 1 | Parity enable |
| even_parity_o | output | 1 | Even parity |
| stick_parity_o | output | 1 | Stick parity |
| break_o | output | 1 | Force break |
| fifo_en_o | output | 1 | FIFOs enabled |
| rx_trig4_o | output | 1 | Receive trigger of 4 characters |
| rx_fifo_clr_o | output | 1 | Receive FIFO clear pulse |
| tx_fifo_clr_o | output | 1 | Transmit FIFO clear pulse |
| dtr_o | output | 1 | Data terminal ready |
| rts_o | output | 1 | Request to send |
| out2_o | output | 1 | Interrupt gate |
| loop_o | output | 1 | Loopback |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that:
- the divisor holds unless a write reaches it while the divisor access bit is set;
- the latched line errors hold between status reads and clear after a read that sees no new pulse;
- a transmit holding write retires the transmitter-empty event;
- a raised `irq_o` is always matched by a pending identification code.

Only the bench scenarios can show the following:
- the full priority walk and the code returned at each level;
- the retire-on-read rule for code 2;
- the overloading of offsets 0 and 1 by the access bit, and the side-effect pulses;
- the FIFO indication in bits 7:6.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DIV_W  = 2 * DATA_W;
  localparam int unsigned IER_W  = 4;
  localparam int unsigned MCR_W  = 5;
  localparam int unsigned ERR_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    OFS_DATA = 3'd0,
    OFS_IEN  = 3'd1,
    OFS_IID  = 3'd2,
    OFS_FMT  = 3'd3,
    OFS_MCTL = 3'd4,
    OFS_LST  = 3'd5,
    OFS_MST  = 3'd6,
    OFS_SCR  = 3'd7
  } ofs_e;

  localparam logic [3:0] IID_NONE  = 4'h1;
  localparam logic [3:0] IID_LINE  = 4'h6;
  localparam logic [3:0] IID_RXD   = 4'h4;
  localparam logic [3:0] IID_TMO   = 4'hC;
  localparam logic [3:0] IID_THRE  = 4'h2;
  localparam logic [3:0] IID_MODEM = 4'h0;
endpackage

// File: rtl/uart_cfg_regs.sv
module uart_cfg_regs
  import uart_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [IER_W-1:0]  ier_o,
  output logic [DATA_W-1:0] lcr_o,
  output logic [MCR_W-1:0]  mcr_o,
  output logic [DATA_W-1:0] scr_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              fifo_en_o,
  output logic              rx_trig4_o
);
  logic dlab;
  assign dlab = lcr_o[DATA_W-1];

  logic [DATA_W-1:0] div_lo_q, div_hi_q;
  assign div_o = {div_hi_q, div_lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ier_o      <= '0;
      lcr_o      <= '0;
      mcr_o      <= '0;
      scr_o      <= '0;
      div_lo_q   <= '0;
      div_hi_q   <= '0;
      fifo_en_o  <= 1'b0;
      rx_trig4_o <= 1'b0;
    end else if (wr_i) begin
      unique case (ofs_e'(addr_i))
        OFS_DATA: if (dlab) div_lo_q <= wdata_i;
        OFS_IEN:  if (dlab) div_hi_q <= wdata_i;
                  else      ier_o    <= wdata_i[IER_W-1:0];
        OFS_IID: begin
          fifo_en_o  <= wdata_i[0];
          rx_trig4_o <= wdata_i[6];
        end
        OFS_FMT:  lcr_o <= wdata_i;
        OFS_MCTL: mcr_o <= wdata_i[MCR_W-1:0];
        OFS_SCR:  scr_o <= wdata_i;
        default: ;
      endcase
    end
  end

  // R2: divisor only moves on a write to offset 0/1 while the access bit is set
  assert_div_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && dlab && addr_i[ADDR_W-1:1] == '0) |=> $stable(div_o));
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
  import uart_reg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ERR_W-1:0] err_pulse_i,
  input  logic             lsr_read_i,
  output logic [ERR_W-1:0] err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         err_o <= '0;
    else if (lsr_read_i) err_o <= err_pulse_i;
    else                 err_o <= err_o | err_pulse_i;
  end

  assert_err_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_read_i && err_pulse_i == '0) |=> err_o == '0);

  assert_err_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lsr_read_i && err_pulse_i == '0) |=> $stable(err_o));
endmodule

// File: rtl/uart_int_id.sv
module uart_int_id
  import uart_reg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IER_W-1:0] ier_i,
  input  logic             line_err_i,
  input  logic             rx_ready_i,
  input  logic             rx_timeout_i,
  input  logic             thr_empty_i,
  input  logic             modem_delta_i,
  input  logic             thr_write_i,
  input  logic             iid_read_i,
  output logic [3:0]       code_o,
  output logic             pending_o
);
  logic thre_pend_q, thr_prev_q, ier1_prev_q;
  logic thre_set, thre_clr;

  assign thre_set = (thr_empty_i && !thr_prev_q) ||
                    (thr_empty_i && ier_i[1] && !ier1_prev_q);
  assign thre_clr = thr_write_i || (iid_read_i && code_o == IID_THRE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thre_pend_q <= 1'b0;
      thr_prev_q  <= 1'b1;
      ier1_prev_q <= 1'b0;
    end else begin
      thr_prev_q  <= thr_empty_i;
      ier1_prev_q <= ier_i[1];
      if (thre_clr)      thre_pend_q <= 1'b0;
      else if (thre_set) thre_pend_q <= 1'b1;
    end
  end

  always_comb begin
    if (ier_i[2] && line_err_i)        code_o = IID_LINE;
    else if (ier_i[0] && rx_timeout_i) code_o = IID_TMO;
    else if (ier_i[0] && rx_ready_i)   code_o = IID_RXD;
    else if (ier_i[1] && thre_pend_q)  code_o = IID_THRE;
    else if (ier_i[3] && modem_delta_i) code_o = IID_MODEM;
    else                                code_o = IID_NONE;
  end
  assign pending_o = !code_o[0];

  assert_thre_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_write_i |=> !thre_pend_q);
endmodule

// File: rtl/uart_reg_unit.sv
module uart_reg_unit
  import uart_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_ready_i,
  input  logic              rx_timeout_i,
  input  logic              rx_overrun_i,
  input  logic              rx_parity_err_i,
  input  logic              rx_frame_err_i,
  input  logic              thr_empty_i,
  input  logic [DATA_W-1:0] msr_i,
  output logic              rx_pop_o,
  output logic              tx_load_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              msr_read_o,
  output logic [DIV_W-1:0]  divisor_o,
  output logic [1:0]        word_len_o,
  output logic              two_stop_o,
  output logic              parity_en_o,
  output logic              even_parity_o,
  output logic              stick_parity_o,
  output logic              break_o,
  output logic              fifo_en_o,
  output logic              rx_trig4_o,
  output logic              rx_fifo_clr_o,
  output logic              tx_fifo_clr_o,
  output logic              dtr_o,
  output logic              rts_o,
  output logic              out2_o,
  output logic              loop_o,
  output logic              irq_o
);
  logic [IER_W-1:0]  ier;
  logic [DATA_W-1:0] lcr, scr;
  logic [MCR_W-1:0]  mcr;
  logic [ERR_W-1:0]  err;
  logic [3:0]        code;
  logic              pending, dlab;

  uart_cfg_regs u_cfg (
    .clk_i, .rst_ni, .addr_i, .wr_i, .wdata_i,
    .ier_o(ier), .lcr_o(lcr), .mcr_o(mcr), .scr_o(scr), .div_o(divisor_o),
    .fifo_en_o, .rx_trig4_o
  );

  assign dlab = lcr[DATA_W-1];

  // side-effect strobes, valid for the strobe cycle
  assign tx_load_o     = wr_i && addr_i == OFS_DATA && !dlab;
  assign tx_data_o     = wdata_i;
  assign rx_pop_o      = rd_i && addr_i == OFS_DATA && !dlab;
  assign msr_read_o    = rd_i && addr_i == OFS_MST;
  assign rx_fifo_clr_o = wr_i && addr_i == OFS_IID && wdata_i[1];
  assign tx_fifo_clr_o = wr_i && addr_i == OFS_IID && wdata_i[2];

  uart_line_status u_lst (
    .clk_i, .rst_ni,
    .err_pulse_i({rx_frame_err_i, rx_parity_err_i, rx_overrun_i}),
    .lsr_read_i(rd_i && addr_i == OFS_LST),
    .err_o(err)
  );

  uart_int_id u_iid (
    .clk_i, .rst_ni,
    .ier_i(ier),
    .line_err_i(|err),
    .rx_ready_i, .rx_timeout_i, .thr_empty_i,
    .modem_delta_i(|msr_i[3:0]),
    .thr_write_i(tx_load_o),
    .iid_read_i(rd_i && addr_i == OFS_IID),
    .code_o(code),
    .pending_o(pending)
  );

  assign word_len_o     = lcr[1:0];
  assign two_stop_o     = lcr[2];
  assign parity_en_o    = lcr[3];
  assign even_parity_o  = lcr[4];
  assign stick_parity_o = lcr[5];
  assign break_o        = lcr[6];
  assign dtr_o  = mcr[0];
  assign rts_o  = mcr[1];
  assign out2_o = mcr[3];
  assign loop_o = mcr[4];
  assign irq_o  = pending && out2_o;

  always_comb begin
    unique case (ofs_e'(addr_i))
      OFS_DATA: rdata_o = dlab ? divisor_o[DATA_W-1:0] : rx_data_i;
      OFS_IEN:  rdata_o = dlab ? divisor_o[DIV_W-1:DATA_W]
                               : {{(DATA_W-IER_W){1'b0}}, ier};
      OFS_IID:  rdata_o = {fifo_en_o, fifo_en_o, 2'b00, code};
      OFS_FMT:  rdata_o = lcr;
      OFS_MCTL: rdata_o = {{(DATA_W-MCR_W){1'b0}}, mcr};
      OFS_LST:  rdata_o = {2'b00, thr_empty_i, 1'b0, err, rx_ready_i};
      OFS_MST:  rdata_o = msr_i;
      OFS_SCR:  rdata_o = scr;
      default:  rdata_o = '0;
    endcase
  end

  assert_irq_pending_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (code != IID_NONE && out2_o));
endmodule

// File: tb/uart_reg_unit_tb.sv
module uart_reg_unit_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [2:0] addr = '0;
  logic wr = 0, rd = 0;
  logic [7:0] wdata = '0, rdata, rx_data = 8'hA5, msr = '0, tx_data;
  logic rx_ready = 0, rx_timeout = 0, ovr = 0, par = 0, frm = 0, thr_empty = 0;
  logic rx_pop, tx_load, msr_read, wlen_dummy;
  logic [15:0] divisor;
  logic [1:0] word_len;
  logic two_stop, parity_en, even_par, stick_par, brk, fifo_en, trig4, rxclr, txclr;
  logic dtr, rts, out2, loopb, irq;

  uart_reg_unit u_dut (
    .clk_i(clk), .rst_ni, .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
    .rdata_o(rdata), .rx_data_i(rx_data), .rx_ready_i(rx_ready),
    .rx_timeout_i(rx_timeout), .rx_overrun_i(ovr), .rx_parity_err_i(par),
    .rx_frame_err_i(frm), .thr_empty_i(thr_empty), .msr_i(msr),
    .rx_pop_o(rx_pop), .tx_load_o(tx_load), .tx_data_o(tx_data),
    .msr_read_o(msr_read), .divisor_o(divisor), .word_len_o(word_len),
    .two_stop_o(two_stop), .parity_en_o(parity_en), .even_parity_o(even_par),
    .stick_parity_o(stick_par), .break_o(brk), .fifo_en_o(fifo_en),
    .rx_trig4_o(trig4), .rx_fifo_clr_o(rxclr), .tx_fifo_clr_o(txclr),
    .dtr_o(dtr), .rts_o(rts), .out2_o(out2), .loop_o(loopb), .irq_o(irq)
  );
  assign wlen_dummy = 1'b0;

  int checks = 0, errors = 0;
  logic s_load, s_pop, s_msrd, s_rxclr, s_txclr;
  logic [7:0] s_txd;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    #1; s_load = tx_load; s_txd = tx_data; s_rxclr = rxclr; s_txclr = txclr;
    @(negedge clk); wr = 0; #1;
  endtask

  task automatic rd_reg(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1;
    #1; d = rdata; s_pop = rx_pop; s_msrd = msr_read;
    @(negedge clk); rd = 0; #1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd_reg(2, d); check("R1 iid", d, 8'h01);
    rd_reg(1, d); check("R1 ier", d, 0);
    rd_reg(3, d); check("R1 fmt", d, 0);
    rd_reg(4, d); check("R1 mctl", d, 0);
    rd_reg(7, d); check("R1 scr", d, 0);
    rd_reg(5, d); check("R1 lst err", d[3:1], 0);
    check("R1 div", divisor, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_divisor();
    logic [7:0] d;
    wr_reg(3, 8'h80);
    wr_reg(0, 8'h34); check("R2 no tx_load", s_load, 0);
    wr_reg(1, 8'h12);
    check("R2 divisor", divisor, 16'h1234);
    rd_reg(0, d); check("R2 dll read", d, 8'h34); check("R2 no pop", s_pop, 0);
    rd_reg(1, d); check("R2 dlm read", d, 8'h12);
    wr_reg(3, 8'h03);
    check("R2 divisor hold", divisor, 16'h1234);
    rd_reg(1, d); check("R3 ier after dlab", d, 8'h00);
  endtask

  task automatic t_data();
    logic [7:0] d;
    wr_reg(0, 8'h5A);
    check("R3 tx_load", s_load, 1); check("R3 tx_data", s_txd, 8'h5A);
    check("R3 divisor untouched", divisor, 16'h1234);
    rx_data = 8'hC3;
    rd_reg(0, d); check("R3 rx read", d, 8'hC3); check("R3 rx_pop", s_pop, 1);
    wr_reg(1, 8'hF0); rd_reg(1, d); check("R3 ier upper", d, 8'h00);
    wr_reg(1, 8'h00);
  endtask

  task automatic t_format();
    logic [7:0] d;
    wr_reg(3, 8'h7C);
    rd_reg(3, d); check("R4 readback", d, 8'h7C);
    check("R4 fields", {word_len, two_stop, parity_en, even_par, stick_par, brk},
          {2'b00, 5'b11111});
    wr_reg(3, 8'h0B);
    check("R4 fields b", {word_len, two_stop, parity_en, even_par, stick_par, brk},
          {2'b11, 5'b01000});
  endtask

  task automatic t_modem_scratch();
    logic [7:0] d;
    wr_reg(4, 8'hFF);
    rd_reg(4, d); check("R5 mctl readback", d, 8'h1F);
    check("R5 pins", {dtr, rts, out2, loopb}, 4'b1111);
    wr_reg(4, 8'h09); check("R5 pins b", {dtr, rts, out2, loopb}, 4'b1010);
    wr_reg(7, 8'h96); rd_reg(7, d); check("R5 scratch", d, 8'h96);
    msr = 8'hB0; rd_reg(6, d);
    check("R11 msr read", d, 8'hB0); check("R11 msr pulse", s_msrd, 1);
    msr = 8'h00;
  endtask

  task automatic t_fifo();
    logic [7:0] d;
    wr_reg(2, 8'h47);
    check("R6 enable trig", {fifo_en, trig4}, 2'b11);
    check("R6 clr pulses", {s_rxclr, s_txclr}, 2'b11);
    check("R6 clr gone", {rxclr, txclr}, 2'b00);
    rd_reg(2, d); check("R6 iid fifo bits", d, 8'hC1);
    wr_reg(2, 8'h00);
    rd_reg(2, d); check("R6 iid fifo off", d, 8'h01);
  endtask

  task automatic t_line_status();
    logic [7:0] d;
    thr_empty = 1;
    @(negedge clk); ovr = 1; frm = 1; @(negedge clk); ovr = 0; frm = 0;
    rx_ready = 1;
    rd_reg(5, d); check("R7 lsr set", d, 8'h2B);
    rd_reg(5, d); check("R7 lsr cleared", d, 8'h21);
    rx_ready = 0; thr_empty = 0;
    rd_reg(5, d); check("R7 lsr idle", d, 8'h00);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    wr_reg(1, 8'h0F);
    @(negedge clk); thr_empty = 1;
    @(negedge clk); #1;
    rx_ready = 1; msr = 8'h01;
    @(negedge clk); par = 1; @(negedge clk); par = 0; #1;
    rd_reg(2, d); check("R8 line first", d, 8'h06);
    check("R10 irq gated by out2", irq, 1);
    rd_reg(5, d);
    rd_reg(2, d); check("R8 rx data", d, 8'h04);
    rx_timeout = 1; #1;
    rd_reg(2, d); check("R8 timeout", d, 8'h0C);
    rx_timeout = 0; rx_ready = 0;
    rd_reg(2, d); check("R8 R9 thre", d, 8'h02);
    rd_reg(2, d); check("R9 thre cleared by read", d, 8'h00);
    msr = 8'h00;
    rd_reg(2, d); check("R8 none", d, 8'h01);
    check("R10 irq low", irq, 0);
    @(negedge clk); thr_empty = 0; @(negedge clk); thr_empty = 1;
    @(negedge clk); #1;
    rd_reg(5, d);
    check("R10 irq thre", irq, 1);
    wr_reg(4, 8'h00); check("R10 out2 off", irq, 0);
    wr_reg(0, 8'h11);
    rd_reg(2, d); check("R9 thre cleared by write", d, 8'h01);
  endtask

  bit done = 0;
  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    t_reset();
    t_divisor();
    t_data();
    t_format();
    t_modem_scratch();
    t_fifo();
    t_line_status();
    t_priority();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule